// File: doc/BRIEF.md
# Floppy Controller Host Register Block

This block is the processor-facing side of a four-drive floppy disk controller. It decodes eight byte-wide I/O offsets. Through them the host reads a subsystem status byte, a result-type code and a result byte. The host also writes a 16-bit pointer to a command block, and it can request a soft reset. Writing the upper pointer byte launches an operation: the block raises a one-cycle start strobe toward a separate command engine, which lies outside this block. The engine later reports completion as either success or an error code.

Completion sets an interrupt flip-flop that drives the interrupt output and is mirrored in the status byte. The host acknowledges the interrupt by reading the result type. The result byte has two views: the stored error code, and a map of which drives are ready. Each read of the result byte returns the view that the current type selects, then switches the type to the other view. The set of attached drives is captured from the ready inputs at hard reset and again at every soft reset.

Top module: `fdc_host_regs`

## Requirements
- R1: In the cycle after a hard reset, status bits 4 and 3 (controller present, double-density present) read 1 and the interrupt bit reads 0. The result type reads 0x02, which means ready-status. `irq_o` is 0.
- R2: A read of offset 0 returns the status byte. Bit 0 is drive 0 ready, bit 1 drive 1, bit 2 the interrupt flip-flop, bit 5 drive 2, bit 6 drive 3, and bit 7 is always 0. The ready bits are latched from `drive_ready_i` only at hard or soft reset, so later changes on that input have no effect until the next reset.
- R3: A write to offset 1 loads the low byte of `cmd_ptr_o`. A write to offset 2 loads the high byte, and `start_o` is high for exactly the one cycle that follows that write and at no other time.
- R4: `done_i` sets the interrupt flip-flop, so `irq_o` and status bit 2 are 1 from the next cycle. If `done_err_i` is 0 the type becomes 0x02. If it is 1 the type becomes 0x00 and `done_code_i` is stored as the error code.
- R5: A read of offset 1 returns the type with bits 7:2 zero; only 0x00 and 0x02 ever occur. The read clears the interrupt flip-flop from the next cycle, except that a completion in the same cycle wins.
- R6: A read of offset 3 returns the error code when the type is 0x00. When the type is 0x02 it returns the ready map: bits 3:0 zero, bit 4 drive 2, bit 5 drive 3, bit 6 drive 0, bit 7 drive 1. The read then flips the type between 0x00 and 0x02, unless a completion in the same cycle sets the type.
- R7: A write to offset 7 is a soft reset. The type becomes 0x02, the interrupt clears, the error code becomes 0x00 and the ready bits are re-latched. The pointer keeps its value. The soft reset takes priority over a completion in the same cycle.
- R8: Reads of offsets 2, 4, 5, 6 and 7 return 0x00. `bus_rdata` is 0x00 whenever no read is in progress. Writes to offsets 0, 3, 4, 5 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| drive_ready_i | input | 4 | Attached/ready flag per drive, sampled at reset |
| done_i | input | 1 | Completion pulse from the command engine |
| done_err_i | input | 1 | Completion ended in error |
| done_code_i | input | 8 | Error code (bit 0 deleted record up to bit 7 not ready) |
| cmd_ptr_o | output | 16 | Command-block pointer |
| start_o | output | 1 | One-cycle start strobe to the command engine |
| irq_o | output | 1 | Interrupt flip-flop |

## Verification
The bench drives the block with several kinds of access pattern, and each one tells apart a different class of fault.

- **Access sequences.** Plain status and type reads check the bit positions. Back-to-back result-byte reads walk the error and ready views in turn and expose a missing or doubled toggle.
- **Input changes after reset.** Changing `drive_ready_i` between resets shows whether the ready bits are truly latched.
- **Coincident events.** A completion in the same cycle as a type read, and a soft reset in the same cycle as a completion, pin down the priority order.
- **Stray writes and reads.** Writes to the offsets that ignore writes, and reads of the offsets that return nothing, are followed by reads of every live register. This shows that no state was disturbed.

// File: rtl/fdc_host_pkg.sv
`timescale 1ns/1ps
package fdc_host_pkg;

  // Offsets whose meaning other logic depends on
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_LO     = 1;  // write: pointer low, read: result type
  localparam int unsigned OFS_HI     = 2;  // write: pointer high + start
  localparam int unsigned OFS_RBYTE  = 3;
  localparam int unsigned OFS_SRST   = 7;
  localparam int unsigned DRIVES     = 4;

  typedef enum logic [1:0] {
    RT_ERROR = 2'b00,
    RT_READY = 2'b10
  } rtype_e;

  // Status byte: ready bits split around the flag bits
  function automatic logic [7:0] pack_status(input logic [DRIVES-1:0] rdy, input logic irq);
    pack_status = {1'b0, rdy[3], rdy[2], 1'b1, 1'b1, irq, rdy[1], rdy[0]};
  endfunction

  // Ready-map view of the result byte
  function automatic logic [7:0] pack_ready(input logic [DRIVES-1:0] rdy);
    pack_ready = {rdy[1], rdy[0], rdy[3], rdy[2], 4'b0000};
  endfunction

endpackage

// File: rtl/fdc_bus_decode.sv
`timescale 1ns/1ps
module fdc_bus_decode #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NUM_OFS = 1 << ADDR_W
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_OFS-1:0] rd_ev,
  output logic              wr_lo_ev,
  output logic              wr_hi_ev,
  output logic              wr_srst_ev
);
  import fdc_host_pkg::*;

  logic rd_cyc, wr_cyc;
  assign rd_cyc = bus_sel && !bus_wr;
  assign wr_cyc = bus_sel && bus_wr;

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_rd
    assign rd_ev[g] = rd_cyc && (bus_addr == ADDR_W'(g));
  end

  assign wr_lo_ev   = wr_cyc && (bus_addr == ADDR_W'(OFS_LO));
  assign wr_hi_ev   = wr_cyc && (bus_addr == ADDR_W'(OFS_HI));
  assign wr_srst_ev = wr_cyc && (bus_addr == ADDR_W'(OFS_SRST));

endmodule

// File: rtl/fdc_ptr_capture.sv
`timescale 1ns/1ps
module fdc_ptr_capture #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 16,
  localparam int unsigned HI_W  = PTR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo_ev,
  input  logic              wr_hi_ev,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              start_o
);
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_hi_ev;
      if (wr_lo_ev) lo_q <= wdata;
      if (wr_hi_ev) hi_q <= wdata[HI_W-1:0];
    end
  end

  assign ptr_o   = {hi_q, lo_q};
  assign start_o = start_q;

endmodule

// File: rtl/fdc_result_state.sv
`timescale 1ns/1ps
module fdc_result_state #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NDRV   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 rd_type,
  input  logic                 rd_rbyte,
  input  logic                 done_i,
  input  logic                 done_err_i,
  input  logic [DATA_W-1:0]    done_code_i,
  input  logic [NDRV-1:0]      drive_ready_i,
  output fdc_host_pkg::rtype_e rtype_o,
  output logic [DATA_W-1:0]    err_code_o,
  output logic [NDRV-1:0]      ready_o,
  output logic                 irq_o
);
  import fdc_host_pkg::*;

  rtype_e            rtype_q;
  logic [DATA_W-1:0] err_q;
  logic [NDRV-1:0]   ready_q;
  logic              irq_q;
  logic              reinit;

  assign reinit = !rst_n || soft_rst;

  always_ff @(posedge clk) begin
    if (reinit) begin
      rtype_q <= RT_READY;
      err_q   <= '0;
      irq_q   <= 1'b0;
      ready_q <= drive_ready_i;
    end else if (done_i) begin
      irq_q   <= 1'b1;
      rtype_q <= done_err_i ? RT_ERROR : RT_READY;
      if (done_err_i) err_q <= done_code_i;
    end else begin
      if (rd_type)  irq_q   <= 1'b0;
      if (rd_rbyte) rtype_q <= (rtype_q == RT_ERROR) ? RT_READY : RT_ERROR;
    end
  end

  assign rtype_o    = rtype_q;
  assign err_code_o = err_q;
  assign ready_o    = ready_q;
  assign irq_o      = irq_q;

endmodule

// File: rtl/fdc_host_regs.sv
`timescale 1ns/1ps
module fdc_host_regs #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned NDRV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NDRV-1:0]   drive_ready_i,
  input  logic              done_i,
  input  logic              done_err_i,
  input  logic [DATA_W-1:0] done_code_i,
  output logic [PTR_W-1:0]  cmd_ptr_o,
  output logic              start_o,
  output logic              irq_o
);
  import fdc_host_pkg::*;

  localparam int unsigned NUM_OFS = 1 << ADDR_W;

  // Named internal events
  logic [NUM_OFS-1:0] rd_ev;
  logic               wr_lo_ev, wr_hi_ev, wr_srst_ev;
  rtype_e             rtype;
  logic [DATA_W-1:0]  err_code;
  logic [NDRV-1:0]    ready_map;
  logic [DATA_W-1:0]  status_view, type_view, rbyte_view;
  logic [DATA_W-1:0]  view [NUM_OFS];

  fdc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .rd_ev     (rd_ev),
    .wr_lo_ev  (wr_lo_ev),
    .wr_hi_ev  (wr_hi_ev),
    .wr_srst_ev(wr_srst_ev)
  );

  fdc_ptr_capture #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo_ev(wr_lo_ev),
    .wr_hi_ev(wr_hi_ev),
    .wdata   (bus_wdata),
    .ptr_o   (cmd_ptr_o),
    .start_o (start_o)
  );

  fdc_result_state #(.DATA_W(DATA_W), .NDRV(NDRV)) u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (wr_srst_ev),
    .rd_type      (rd_ev[OFS_LO]),
    .rd_rbyte     (rd_ev[OFS_RBYTE]),
    .done_i       (done_i),
    .done_err_i   (done_err_i),
    .done_code_i  (done_code_i),
    .drive_ready_i(drive_ready_i),
    .rtype_o      (rtype),
    .err_code_o   (err_code),
    .ready_o      (ready_map),
    .irq_o        (irq_o)
  );

  assign status_view = pack_status(ready_map, irq_o);
  assign type_view   = {{(DATA_W-2){1'b0}}, rtype};
  assign rbyte_view  = (rtype == RT_ERROR) ? err_code : pack_ready(ready_map);

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_view
    if (g == OFS_STATUS) begin : g_s
      assign view[g] = status_view;
    end else if (g == OFS_LO) begin : g_t
      assign view[g] = type_view;
    end else if (g == OFS_RBYTE) begin : g_r
      assign view[g] = rbyte_view;
    end else begin : g_z
      assign view[g] = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_OFS; i++) begin
      if (rd_ev[i]) bus_rdata = view[i];
    end
  end

endmodule

// File: rtl/fdc_host_regs_chk.sv
`timescale 1ns/1ps
module fdc_host_regs_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned NDRV   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              done_i,
  input logic              start_o,
  input logic              irq_o
);
  logic rd_c, wr_hi_c, srst_c, rd_type_c, rd_stat_c, rd_dead_c;
  assign rd_c      = bus_sel && !bus_wr;
  assign wr_hi_c   = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));
  assign srst_c    = bus_sel && bus_wr && (bus_addr == ADDR_W'(7));
  assign rd_type_c = rd_c && (bus_addr == ADDR_W'(1));
  assign rd_stat_c = rd_c && (bus_addr == ADDR_W'(0));
  assign rd_dead_c = rd_c && (bus_addr >= ADDR_W'(4));

  assert_stat_present_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_c |-> bus_rdata[4:3] == 2'b11);
  assert_stat_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_c |-> !bus_rdata[7]);
  assert_start_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_c |=> start_o);
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !wr_hi_c) |=> !start_o);
  assert_done_sets_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !srst_c) |=> irq_o);
  assert_stat_irq_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_c |-> bus_rdata[2] == irq_o);
  assert_type_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_type_c && !done_i) |=> !irq_o);
  assert_type_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_type_c |-> (bus_rdata[DATA_W-1:2] == '0 && !bus_rdata[0]));
  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_c |=> !irq_o);
  assert_dead_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dead_c |-> bus_rdata == '0);
  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_c |-> bus_rdata == '0);

endmodule

bind fdc_host_regs fdc_host_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .NDRV(NDRV)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .done_i   (done_i),
  .start_o  (start_o),
  .irq_o    (irq_o)
);

// File: tb/fdc_host_regs_tb.sv
`timescale 1ns/1ps
module fdc_host_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  drive_ready = 4'b0101;
  logic        done = 1'b0, done_err = 1'b0;
  logic [7:0]  done_code = '0;
  logic [15:0] cmd_ptr;
  logic        start, irq;

  int n_chk = 0, n_err = 0;
  bit armed = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  fdc_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drive_ready_i(drive_ready), .done_i(done), .done_err_i(done_err),
    .done_code_i(done_code), .cmd_ptr_o(cmd_ptr), .start_o(start), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_type, m_err, m_irq, m_start, m_ptr;
  int m_rdy [4];

  function automatic int m_status();
    return m_rdy[0] + 2*m_rdy[1] + 4*m_irq + 8 + 16 + 32*m_rdy[2] + 64*m_rdy[3];
  endfunction
  function automatic int m_readymap();
    return 16*m_rdy[2] + 32*m_rdy[3] + 64*m_rdy[0] + 128*m_rdy[1];
  endfunction
  function automatic int m_read();
    if (!(bus_sel && !bus_wr)) return 0;
    case (bus_addr)
      3'd0: return m_status();
      3'd1: return m_type;
      3'd3: return (m_type == 0) ? m_err : m_readymap();
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit rd, wr;
    rd = bus_sel && !bus_wr;
    wr = bus_sel && bus_wr;
    if (!rst_n || (wr && bus_addr == 3'd7)) begin
      if (!rst_n) begin m_ptr = 0; m_start = 0; end
      else m_start = 0;
      m_type = 2; m_err = 0; m_irq = 0;
      for (int k = 0; k < 4; k++) m_rdy[k] = drive_ready[k];
    end else begin
      m_start = (wr && bus_addr == 3'd2) ? 1 : 0;
      if (done) begin
        m_irq = 1;
        m_type = done_err ? 0 : 2;
        if (done_err) m_err = done_code;
      end else begin
        if (rd && bus_addr == 3'd1) m_irq = 0;
        if (rd && bus_addr == 3'd3) m_type = (m_type == 0) ? 2 : 0;
      end
    end
    if (rst_n && wr && bus_addr == 3'd1) m_ptr = (m_ptr & 16'hFF00) | bus_wdata;
    if (rst_n && wr && bus_addr == 3'd2) m_ptr = (m_ptr & 16'h00FF) | (int'(bus_wdata) << 8);
    armed = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && armed) begin
      string rq;
      case (bus_addr)
        3'd0: rq = "R2 rdata";
        3'd1: rq = "R5 rdata";
        3'd3: rq = "R6 rdata";
        default: rq = "R8 rdata";
      endcase
      check("R4 irq_o", int'(irq), m_irq);
      check("R3 start_o", int'(start), m_start);
      check("R3 cmd_ptr_o", int'(cmd_ptr), m_ptr);
      check(rq, int'(bus_rdata), m_read());
    end
  end

  // called at posedge+1; returns read data seen before the next edge
  task automatic access(input bit wr, input int a, input int d, output int rd);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = 3'(a); bus_wdata = 8'(d);
    #1 rd = int'(bus_rdata);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input int exp);
    int v;
    access(1'b0, a, 0, v);
    check(req, v, exp);
  endtask

  task automatic wr(input int a, input int d);
    int v;
    access(1'b1, a, d, v);
  endtask

  task automatic complete(input bit e, input int code);
    done = 1'b1; done_err = e; done_code = 8'(code);
    @(posedge clk); #1;
    done = 1'b0; done_err = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check("R1 irq after reset", int'(irq), 0);
    rd_chk("R1 status after reset", 0, 8'h39);
    rd_chk("R1 type after reset", 1, 8'h02);

    // R2: ready bits latched, later input changes ignored
    drive_ready = 4'b1111;
    @(posedge clk); #1;
    rd_chk("R2 status latched", 0, 8'h39);

    // R3: pointer and start strobe
    wr(1, 8'h34);
    check("R3 no start on low write", int'(start), 0);
    wr(2, 8'h12);
    check("R3 start pulse", int'(start), 1);
    check("R3 pointer", int'(cmd_ptr), 16'h1234);
    @(posedge clk); #1;
    check("R3 start single cycle", int'(start), 0);
    wr(2, 8'hAB);
    check("R3 pointer high rewrite", int'(cmd_ptr), 16'hAB34);

    // R4 + R5: successful completion, acknowledge
    complete(1'b0, 0);
    check("R4 irq set", int'(irq), 1);
    rd_chk("R4 status irq bit", 0, 8'h3D);
    rd_chk("R5 type ok", 1, 8'h02);
    check("R5 irq cleared", int'(irq), 0);
    rd_chk("R5 status cleared", 0, 8'h39);

    // R4 + R6: error completion, result byte alternation
    complete(1'b1, 8'h88);
    rd_chk("R4 type error", 1, 8'h00);
    rd_chk("R6 error code", 3, 8'h88);
    rd_chk("R6 flipped to ready", 1, 8'h02);
    rd_chk("R6 ready map", 3, 8'h50);
    rd_chk("R6 back to error", 3, 8'h88);
    rd_chk("R6 ready map again", 3, 8'h50);

    // R5: completion coinciding with type read wins
    done = 1'b1; done_err = 1'b0;
    access(1'b0, 1, 0, v);
    done = 1'b0;
    check("R5 done beats clear", int'(irq), 1);
    rd_chk("R5 clear after", 1, 8'h02);

    // R6: result-byte read coinciding with error completion
    done = 1'b1; done_err = 1'b1; done_code = 8'h21;
    access(1'b0, 3, 0, v);
    done = 1'b0; done_err = 1'b0;
    rd_chk("R6 done beats toggle", 1, 8'h00);
    rd_chk("R6 new code", 3, 8'h21);

    // R8: stray writes and dead reads
    wr(0, 8'hFF); wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF); wr(6, 8'hFF);
    rd_chk("R8 status unchanged", 0, 8'h39);
    rd_chk("R8 type unchanged", 1, 8'h02);
    check("R8 pointer unchanged", int'(cmd_ptr), 16'hAB34);
    rd_chk("R8 read 2", 2, 0);
    rd_chk("R8 read 4", 4, 0);
    rd_chk("R8 read 5", 5, 0);
    rd_chk("R8 read 6", 6, 0);
    rd_chk("R8 read 7", 7, 0);

    // R7: soft reset re-latches ready, clears code and irq
    complete(1'b1, 8'h04);
    wr(7, 0);
    check("R7 irq cleared", int'(irq), 0);
    check("R7 pointer kept", int'(cmd_ptr), 16'hAB34);
    rd_chk("R7 status relatched", 0, 8'h7B);
    rd_chk("R7 type ready", 1, 8'h02);
    rd_chk("R7 ready map", 3, 8'hF0);
    rd_chk("R7 code cleared", 3, 8'h00);

    // R7: soft reset beats a coincident completion
    done = 1'b1; done_err = 1'b1; done_code = 8'h80;
    wr(7, 0);
    done = 1'b0; done_err = 1'b0;
    check("R7 beats done irq", int'(irq), 0);
    rd_chk("R7 beats done type", 1, 8'h02);

    repeat (3) @(posedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule